// File: doc/BRIEF.md
# VME Slave Address-Space Decoder

This block sits behind the bus interface of a VME slave module. On every qualified bus cycle it looks at the address modifier code and the address lines. It then decides which of four address spaces, if any, the module answers in. The four spaces are the configuration space (CR/CSR), the A16 register space, the A24 memory space and the A32 chained block-transfer readout space. The result is a registered one-hot select and a registered offset within the chosen window, both handed to the downstream register file, memory port or readout engine.

The block also holds the small configuration space. It has two read-only identity words and a control/status word that carries an 8-bit base register. Only the upper five bits of the base register are meaningful. The same five bits locate the module in all three data spaces, each at a different address position. The configuration space itself is always found at the slot position given by the active-low geographic address pins. A synchronous reset loads the base register from those same pins, so a module answers at its slot position until software moves it.

Cycles are presented as a one-clock strobe together with the write flag, modifier, address and write data. Handshake timing, acknowledge generation and data-bus transceiver control belong to the surrounding interface.

Top module: `vme_space_decoder`

## Requirements
- R1: Modifier 0x37 with A23:A19 equal to the slot number (the bitwise inverse of the active-low geographic pins) selects the configuration space, sel_o = 4'b0001, with offset A18:A0. A mismatch on A23:A19 selects nothing.
- R2: Modifier 0x29 with A15:A11 equal to base bits [7:3] selects the A16 register space, sel_o = 4'b0010, with offset A10:A0. Address bits above A15 are ignored.
- R3: Modifier 0x39 with A23:A19 equal to base bits [7:3] selects the A24 memory space, sel_o = 4'b0100, with offset A18:A0.
- R4: Modifier 0x0B on a read with A31:A27 equal to base bits [7:3] selects the A32 readout space, sel_o = 4'b1000, with offset A26:A0. A write with modifier 0x0B selects nothing.
- R5: Any other modifier code, or a base mismatch, gives sel_o = 0, offset_o = 0 and cfg_rdata_o = 0.
- R6: After reset, sel_o = 0, offset_o = 0 and cfg_rdata_o = 0. The base register holds {slot number, 3'b000}.
- R7: A configuration write at offset 0x0004 loads base bits [7:3] from write-data bits [15:11]. Base bits [2:0] stay zero. The new base governs decoding from the next strobe onward.
- R8: A configuration read returns its word in cfg_rdata_o. Offset 0x0000 gives {8'hA6, 8'h00}. Offset 0x0002 gives {1'b0, module ID[6:0], module revision[7:0]}. Offset 0x0004 gives {base[7:0], 8'h00}. Any other offset gives zero.
- R9: Configuration writes to offsets 0x0000 and 0x0002 have no effect. Neither identity word nor the base register changes.
- R10: All outputs are registered and appear one clock after the strobe. At most one select bit is set, and sel_o is zero in any cycle that follows a clock without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | One-clock bus cycle strobe |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| am_i | input | 6 | Address modifier code |
| addr_i | input | 32 | Bus address |
| ga_n_i | input | 5 | Geographic address pins, active low |
| wdata_i | input | 16 | Write data for the configuration space |
| sel_o | output | 4 | One-hot space select: [0] config, [1] A16, [2] A24, [3] A32 |
| offset_o | output | 27 | Offset inside the selected window |
| cfg_rdata_o | output | 16 | Configuration read data |

## Verification
Select, offset and configuration read data are registered once, so each is due exactly one clock after the strobe edge. The only exception is a base change: it takes effect at the strobe edge of the write and so governs the very next strobe. The bench records a strobe as seen at a rising edge and compares the popped expectation shortly after that same edge, when the registers have settled. It checks an idle select in every cycle that follows no strobe. Back-to-back strobes are issued right after a base write, so the one-cycle take-effect rule is checked directly.

// File: rtl/vme_dec_pkg.sv
package vme_dec_pkg;

  typedef enum logic [1:0] {
    SP_CFG = 2'd0,
    SP_A16 = 2'd1,
    SP_A24 = 2'd2,
    SP_A32 = 2'd3
  } space_e;

  localparam int NUM_SPACES = 4;

  localparam logic [5:0] AM_CFG = 6'h37;
  localparam logic [5:0] AM_A16 = 6'h29;
  localparam logic [5:0] AM_A24 = 6'h39;
  localparam logic [5:0] AM_A32 = 6'h0B;

  // Highest address bit of the compared field in each space
  function automatic int space_top_bit(input int s);
    case (s)
      0:       return 23;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

endpackage

// File: rtl/vme_am_classify.sv
module vme_am_classify
  import vme_dec_pkg::*;
#(
  parameter int AMW = 6
) (
  input  logic [AMW-1:0] am,
  input  logic           wr,
  output space_e         space,
  output logic           known
);

  always_comb begin
    space = SP_CFG;
    known = 1'b0;
    case (am)
      AM_CFG: begin space = SP_CFG; known = 1'b1; end
      AM_A16: begin space = SP_A16; known = 1'b1; end
      AM_A24: begin space = SP_A24; known = 1'b1; end
      AM_A32: begin space = SP_A32; known = !wr; end
      default: begin space = SP_CFG; known = 1'b0; end
    endcase
  end

endmodule

// File: rtl/vme_window_match.sv
module vme_window_match
  import vme_dec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 5,
  parameter int OFF_W = AW - CW
) (
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    base_top,
  input  logic [CW-1:0]    slot,
  input  space_e           space,
  output logic             match,
  output logic [OFF_W-1:0] offset
);

  logic [NUM_SPACES-1:0] hit_vec;
  logic [OFF_W-1:0]      off_vec [NUM_SPACES];

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    localparam int TOP   = space_top_bit(s);
    localparam int LOW_W = TOP - CW + 1;
    logic [CW-1:0] ref_bits;
    if (s == int'(SP_CFG)) begin : g_slot
      assign ref_bits = slot;
    end else begin : g_base
      assign ref_bits = base_top;
    end
    assign hit_vec[s] = (addr[TOP -: CW] == ref_bits);
    assign off_vec[s] = OFF_W'(addr[LOW_W-1:0]);
  end

  always_comb begin
    match  = hit_vec[space];
    offset = off_vec[space];
  end

endmodule

// File: rtl/vme_cfg_bank.sv
module vme_cfg_bank #(
  parameter int         CW         = 5,
  parameter int         BW         = 8,
  parameter int         DW         = 16,
  parameter int         OFF_W      = 27,
  parameter logic [7:0] VENDOR_ID  = 8'hA6,
  parameter logic [6:0] MODULE_ID  = 7'h15,
  parameter logic [7:0] MODULE_REV = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    slot,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] offset,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [CW-1:0]    base_top
);

  localparam int PAD_W = BW - CW;
  localparam logic [OFF_W-1:0] OFS_VENDOR = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFS_MODULE = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFS_BASE   = OFF_W'(4);

  logic [CW-1:0] base_q;
  logic          unused_wdata;

  assign unused_wdata = ^wdata[DW-CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= slot;
    end else if (wr_en && offset == OFS_BASE) begin
      base_q <= wdata[DW-1 -: CW];
    end
  end

  always_comb begin
    case (offset)
      OFS_VENDOR: rdata = DW'({VENDOR_ID, 8'h00});
      OFS_MODULE: rdata = DW'({1'b0, MODULE_ID, MODULE_REV});
      OFS_BASE:   rdata = DW'({base_q, {PAD_W{1'b0}}, 8'h00});
      default:    rdata = '0;
    endcase
  end

  assign base_top = base_q;

endmodule

// File: rtl/vme_space_decoder.sv
module vme_space_decoder
  import vme_dec_pkg::*;
#(
  parameter int         AW         = 32,
  parameter int         AMW        = 6,
  parameter int         DW         = 16,
  parameter int         CW         = 5,
  parameter int         BW         = 8,
  parameter logic [7:0] VENDOR_ID  = 8'hA6,
  parameter logic [6:0] MODULE_ID  = 7'h15,
  parameter logic [7:0] MODULE_REV = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cyc_i,
  input  logic                  wr_i,
  input  logic [AMW-1:0]        am_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [CW-1:0]         ga_n_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NUM_SPACES-1:0] sel_o,
  output logic [AW-CW-1:0]      offset_o,
  output logic [DW-1:0]         cfg_rdata_o
);

  localparam int OFF_W = AW - CW;

  space_e           space;
  logic             known;
  logic             match;
  logic [OFF_W-1:0] offset;
  logic [CW-1:0]    slot;
  logic [CW-1:0]    base_q;
  logic [DW-1:0]    cfg_rdata;
  logic             hit;
  logic             cfg_wr;
  logic             cfg_rd;

  assign slot = ~ga_n_i;

  vme_am_classify #(.AMW(AMW)) u_class (
    .am    (am_i),
    .wr    (wr_i),
    .space (space),
    .known (known)
  );

  vme_window_match #(.AW(AW), .CW(CW), .OFF_W(OFF_W)) u_match (
    .addr     (addr_i),
    .base_top (base_q),
    .slot     (slot),
    .space    (space),
    .match    (match),
    .offset   (offset)
  );

  assign hit    = cyc_i && known && match;
  assign cfg_wr = hit && (space == SP_CFG) && wr_i;
  assign cfg_rd = hit && (space == SP_CFG) && !wr_i;

  vme_cfg_bank #(
    .CW(CW), .BW(BW), .DW(DW), .OFF_W(OFF_W),
    .VENDOR_ID(VENDOR_ID), .MODULE_ID(MODULE_ID), .MODULE_REV(MODULE_REV)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .wr_en    (cfg_wr),
    .offset   (offset),
    .wdata    (wdata_i),
    .rdata    (cfg_rdata),
    .base_top (base_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o       <= '0;
      offset_o    <= '0;
      cfg_rdata_o <= '0;
    end else begin
      sel_o       <= hit ? NUM_SPACES'(1) << space : '0;
      offset_o    <= hit ? offset : '0;
      cfg_rdata_o <= cfg_rd ? cfg_rdata : '0;
    end
  end

endmodule

// File: rtl/vme_space_decoder_chk.sv
module vme_space_decoder_chk #(
  parameter int AW  = 32,
  parameter int AMW = 6,
  parameter int CW  = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           cyc_i,
  input logic           wr_i,
  input logic [AMW-1:0] am_i,
  input logic [AW-1:0]  addr_i,
  input logic [CW-1:0]  ga_n_i,
  input logic [3:0]     sel_o,
  input logic [CW-1:0]  base_q
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cyc_i |=> sel_o == 4'b0000); // R10

  AST_A32_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    cyc_i && wr_i |=> !sel_o[3]); // R4

  AST_BAD_AM_SILENT: assert property (@(posedge clk) disable iff (rst)
    cyc_i && am_i != 6'h37 && am_i != 6'h29 && am_i != 6'h39 && am_i != 6'h0B
    |=> sel_o == 4'b0000); // R5

  AST_CFG_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
    cyc_i && am_i == 6'h37 && addr_i[23:19] != ~ga_n_i |=> !sel_o[0]); // R1

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && wr_i && am_i == 6'h37) |=> $stable(base_q)); // R9

endmodule

bind vme_space_decoder vme_space_decoder_chk #(.AW(AW), .AMW(AMW), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cyc_i  (cyc_i),
  .wr_i   (wr_i),
  .am_i   (am_i),
  .addr_i (addr_i),
  .ga_n_i (ga_n_i),
  .sel_o  (sel_o),
  .base_q (base_q)
);

// File: tb/tb_vme_space_decoder.sv
`timescale 1ns/1ps
module tb_vme_space_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [5:0]  am_i = '0;
  logic [31:0] addr_i = '0;
  logic [4:0]  ga_n_i = 5'b10100; // slot 11
  logic [15:0] wdata_i = '0;
  logic [3:0]  sel_o;
  logic [26:0] offset_o;
  logic [15:0] cfg_rdata_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [3:0]  sel;
    logic [26:0] off;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  vme_space_decoder dut (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .wr_i(wr_i), .am_i(am_i),
    .addr_i(addr_i), .ga_n_i(ga_n_i), .wdata_i(wdata_i),
    .sel_o(sel_o), .offset_o(offset_o), .cfg_rdata_o(cfg_rdata_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic bus(input logic [5:0] am, input logic [31:0] a, input bit w,
                     input logic [15:0] d, input logic [3:0] es,
                     input logic [26:0] eo, input logic [15:0] er, input string tag);
    exp_t e;
    @(negedge clk);
    cyc_i = 1'b1; am_i = am; addr_i = a; wr_i = w; wdata_i = d;
    e.sel = es; e.off = eo; e.rd = er; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_i = 1'b0; wr_i = 1'b0; am_i = '0; addr_i = '0; wdata_i = '0;
    end
  endtask

  // Monitor: a strobe seen at an edge is due right after that edge
  initial begin
    forever begin
      bit hit;
      @(posedge clk);
      hit = cyc_i && !rst;
      #2;
      if (rst) continue;
      if (hit) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected strobe", 0, 0);
        end else begin
          e = exp_q.pop_front();
          check(sel_o == e.sel, e.tag, "sel", 32'(sel_o), 32'(e.sel));
          check(offset_o == e.off, e.tag, "offset", 32'(offset_o), 32'(e.off));
          check(cfg_rdata_o == e.rd, e.tag, "rdata", 32'(cfg_rdata_o), 32'(e.rd));
        end
      end else begin
        check(sel_o == 4'b0000, "R10", "idle sel", 32'(sel_o), 0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(sel_o == 4'b0, "R6", "reset sel", 32'(sel_o), 0);
    check(offset_o == 27'd0, "R6", "reset offset", 32'(offset_o), 0);
    check(cfg_rdata_o == 16'd0, "R6", "reset rdata", 32'(cfg_rdata_o), 0);

    // Configuration space at slot 11: A23:A19 = 01011 -> 0x58_0000
    bus(6'h37, 32'h0058_0000, 0, 0, 4'b0001, 27'h0, 16'hA600, "R8_vendor");
    idle(1);
    bus(6'h37, 32'h0058_0002, 0, 0, 4'b0001, 27'h2, 16'h1503, "R8_module");
    idle(1);
    bus(6'h37, 32'h0058_0004, 0, 0, 4'b0001, 27'h4, 16'h5800, "R6_base_reset");
    bus(6'h37, 32'h0058_0006, 0, 0, 4'b0001, 27'h6, 16'h0000, "R8_other");
    idle(1);
    bus(6'h37, 32'h0060_0000, 0, 0, 4'b0000, 27'h0, 16'h0000, "R1_wrong_slot");
    idle(1);
    // Data spaces with reset base 0x58 (top five bits 01011)
    bus(6'h29, 32'hFFFF_5923, 0, 0, 4'b0010, 27'h123, 16'h0, "R2_a16_hit");
    bus(6'h29, 32'h0000_6123, 0, 0, 4'b0000, 27'h0, 16'h0, "R5_a16_miss");
    bus(6'h39, 32'h0058_1234, 1, 16'hFFFF, 4'b0100, 27'h1234, 16'h0, "R3_a24_hit");
    bus(6'h39, 32'h0068_1234, 0, 0, 4'b0000, 27'h0, 16'h0, "R5_a24_miss");
    bus(6'h0B, 32'h5800_0040, 0, 0, 4'b1000, 27'h40, 16'h0, "R4_a32_read");
    bus(6'h0B, 32'h5800_0040, 1, 0, 4'b0000, 27'h0, 16'h0, "R4_a32_write");
    bus(6'h3D, 32'h0058_0000, 0, 0, 4'b0000, 27'h0, 16'h0, "R5_bad_am");
    idle(2);
    // Move the base: write 0xA7FF -> base 0xA0, low bits forced to zero
    bus(6'h37, 32'h0058_0004, 1, 16'hA7FF, 4'b0001, 27'h4, 16'h0, "R7_base_write");
    bus(6'h29, 32'h0000_A007, 0, 0, 4'b0010, 27'h7, 16'h0, "R7_new_base_next");
    bus(6'h29, 32'h0000_5923, 0, 0, 4'b0000, 27'h0, 16'h0, "R7_old_base_miss");
    bus(6'h37, 32'h0058_0004, 0, 0, 4'b0001, 27'h4, 16'hA000, "R7_readback");
    bus(6'h0B, 32'hA000_0010, 0, 0, 4'b1000, 27'h10, 16'h0, "R7_a32_new");
    bus(6'h39, 32'h00A0_0008, 0, 0, 4'b0100, 27'h8, 16'h0, "R7_a24_new");
    idle(1);
    // Writes to identity words are ignored
    bus(6'h37, 32'h0058_0000, 1, 16'h1234, 4'b0001, 27'h0, 16'h0, "R9_wr_vendor");
    bus(6'h37, 32'h0058_0002, 1, 16'hFFFF, 4'b0001, 27'h2, 16'h0, "R9_wr_module");
    bus(6'h37, 32'h0058_0000, 0, 0, 4'b0001, 27'h0, 16'hA600, "R9_vendor_kept");
    bus(6'h37, 32'h0058_0002, 0, 0, 4'b0001, 27'h2, 16'h1503, "R9_module_kept");
    bus(6'h37, 32'h0058_0004, 0, 0, 4'b0001, 27'h4, 16'hA000, "R9_base_kept");
    idle(3);

    // Reset restores the slot-derived base
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    bus(6'h37, 32'h0058_0004, 0, 0, 4'b0001, 27'h4, 16'h5800, "R6_base_after_reset");
    idle(3);

    wait (exp_q.size() == 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule